// File: doc/BRIEF.md
# Banked Clock Divider with Rate Select

This block takes a fast source clock and produces two derived clocks from it: one at half the source rate and one at a quarter of the source rate. Both have exactly 50% duty cycle, whatever the duty cycle of the source. The quarter-rate clock is built from the half-rate clock, so every rising edge of the quarter-rate clock falls on a rising edge of the half-rate clock. The derived clocks are fanned out to four banks of three outputs each.

A 2-bit select gives a count of banks, from 0 to 3, that carry the quarter-rate clock. The banks are taken from the lowest-numbered bank upward. The last bank always carries the half-rate clock. A falling edge on the clear input puts the quarter-rate divider back to its start phase and leaves the half-rate divider running. A test input bypasses both dividers and drives the raw source clock onto every output.

An active-high disable turns off all twelve outputs. High impedance is shown through a per-output pad-enable bus, so the pad ring owns the tristate buffers. The phase-lock loop and all analog timing sit outside this block.

Top module: `clk_bank_divider`

## Requirements
- R1: Once running, the half-rate clock toggles on every rising edge of the source clock, which gives 50% duty cycle.
- R2: The quarter-rate clock toggles only on source edges where the half-rate clock rises. Each of its rising edges therefore coincides with a rising edge of the half-rate clock.
- R3: Bank k (k = 1, 2, 3) carries the quarter-rate clock when the unsigned value of `sel_i` is at least k. Otherwise it carries the half-rate clock. The values are: 0 means no quarter banks, 1 means bank 1, 2 means banks 1 and 2, 3 means banks 1 to 3.
- R4: Bank k drives bits `y_o[3k-1:3k-3]`, and all three bits of a bank always carry the same value.
- R5: Bank 4 (`y_o[11:9]`) carries the half-rate clock for every value of `sel_i`.
- R6: A falling edge of `clr_i` forces the quarter-rate clock low at the first source rising edge after the fall, even if the half-rate clock rises on that edge. The quarter-rate clock then rises again at the next half-rate rising edge. The half-rate clock is not disturbed.
- R7: While `rst_ni` is low, both derived clocks are low. After `rst_ni` rises, they stay low through the first two source rising edges. Both rise together on the third.
- R8: With `oe_ni` high, every bit of `y_oe_o` is 0 and every bit of `y_o` is 0, whatever the test and select inputs are. With `oe_ni` low, every bit of `y_oe_o` is 1.
- R9: With `test_i` high and `oe_ni` low, all twelve bits of `y_o` follow `src_clk_i` directly, whatever the value of `sel_i`.
- R10: Changes to `sel_i`, `test_i` and `oe_ni` reach `y_o` and `y_oe_o` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Fast source clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_i | input | 1 | Quarter-rate resync; acts on its falling edge |
| sel_i | input | 2 | Count of banks, starting at bank 1, that carry the quarter-rate clock |
| test_i | input | 1 | High: bypass the dividers and drive the source clock |
| oe_ni | input | 1 | High: disable all outputs |
| y_o | output | 12 | Clock outputs, bank k in bits 3k-1 down to 3k-3 |
| y_oe_o | output | 12 | Per-output pad enable, 1 means drive |

## Verification
Select, test and disable reach the outputs through logic only, with no register in the path. The bench therefore checks them half a nanosecond after it drives them, inside the same low phase of the source clock. Divider state changes on a source rising edge, so divider results are checked at the next falling edge. A clear dropped between edges shows up as a low quarter-rate clock at the falling edge after the next rising edge. It is checked both when the half-rate clock is about to rise and when it is about to fall. The reset release result is due after exactly two synchronizer edges, and the bench checks the first three falling edges one by one against fixed values.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Rate a bank carries when the dividers are in use.
  typedef enum logic {
    RATE_HALF    = 1'b0,
    RATE_QUARTER = 1'b1
  } rate_e;

  // Depth of the reset release synchronizer.
  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/clkdiv_rst_sync.sv
`timescale 1ns/1ps
module clkdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign rst_sync_no = stage_q[STAGES-1];

endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic half_o,
  output logic quarter_o
);

  logic half_q, half_d;
  logic quar_q, quar_d, quar_en;
  logic clr_q, clr_fall;

  // A falling edge of the clear input is seen as a 1-to-0 step between samples.
  assign clr_fall = clr_q & ~clr_i;
  // The quarter divider moves only when the half clock is about to rise, or on a clear.
  assign quar_en  = clr_fall | ~half_q;

  always_comb begin
    half_d = ~half_q;
    quar_d = quar_q;
    if (quar_en) quar_d = clr_fall ? 1'b0 : ~quar_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      quar_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      half_q <= half_d;
      quar_q <= quar_d;
      clr_q  <= clr_i;
    end
  end

  assign half_o    = half_q;
  assign quarter_o = quar_q;

  // R1: the half clock alternates on every running edge
  p_half_toggle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (half_q != $past(half_q)));

  // R2: the quarter clock only rises together with the half clock
  p_quarter_on_half_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(quar_q) |-> $rose(half_q));

  // R6: a clear fall leaves the quarter clock low after the next edge
  p_clear_forces_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_fall |=> !quar_q);

endmodule

// File: rtl/clkdiv_bank_mux.sv
`timescale 1ns/1ps
module clkdiv_bank_mux
  import clkdiv_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 4,
  parameter int unsigned OUTS_PER_BANK = 3,
  parameter int unsigned SEL_W         = 2,
  localparam int unsigned NUM_OUTS     = NUM_BANKS * OUTS_PER_BANK
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                half_i,
  input  logic                quarter_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                test_i,
  input  logic                oe_ni,
  output logic [NUM_OUTS-1:0] y_o,
  output logic [NUM_OUTS-1:0] y_oe_o
);

  logic [NUM_BANKS-1:0] bank_clk;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    rate_e rate;
    logic  div_clk;
    if (b == NUM_BANKS - 1) begin : g_fixed
      assign rate = RATE_HALF;
    end else begin : g_sel
      assign rate = (sel_i > SEL_W'(b)) ? RATE_QUARTER : RATE_HALF;
    end
    assign div_clk     = (rate == RATE_QUARTER) ? quarter_i : half_i;
    assign bank_clk[b] = oe_ni ? 1'b0 : (test_i ? clk_i : div_clk);
    for (genvar o = 0; o < OUTS_PER_BANK; o++) begin : g_out
      assign y_o[b*OUTS_PER_BANK + o]    = bank_clk[b];
      assign y_oe_o[b*OUTS_PER_BANK + o] = ~oe_ni;
    end
  end

  // R4: the outputs of each bank agree
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    p_bank_uniform_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(y_o[b*OUTS_PER_BANK +: OUTS_PER_BANK]) == 0) ||
      ($countones(y_o[b*OUTS_PER_BANK +: OUTS_PER_BANK]) == OUTS_PER_BANK));
  end

  // R8: a disabled block drives nothing
  p_disable_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (y_oe_o == '0) && (y_o == '0));

  // R5: the last bank carries the half clock in normal mode
  p_last_bank_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && !test_i) |-> (y_o[NUM_OUTS-1] == half_i));

endmodule

// File: rtl/clk_bank_divider.sv
`timescale 1ns/1ps
module clk_bank_divider
  import clkdiv_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 4,
  parameter int unsigned OUTS_PER_BANK = 3,
  localparam int unsigned SEL_W        = $clog2(NUM_BANKS),
  localparam int unsigned NUM_OUTS     = NUM_BANKS * OUTS_PER_BANK
) (
  input  logic                src_clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                test_i,
  input  logic                oe_ni,
  output logic [NUM_OUTS-1:0] y_o,
  output logic [NUM_OUTS-1:0] y_oe_o
);

  logic rst_sync_n;
  logic half_clk;
  logic quar_clk;

  clkdiv_rst_sync #(
    .STAGES(RST_SYNC_STAGES)
  ) u_rst_sync (
    .clk_i      (src_clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  clkdiv_core u_core (
    .clk_i    (src_clk_i),
    .rst_ni   (rst_sync_n),
    .clr_i    (clr_i),
    .half_o   (half_clk),
    .quarter_o(quar_clk)
  );

  clkdiv_bank_mux #(
    .NUM_BANKS    (NUM_BANKS),
    .OUTS_PER_BANK(OUTS_PER_BANK),
    .SEL_W        (SEL_W)
  ) u_bank_mux (
    .clk_i    (src_clk_i),
    .rst_ni   (rst_sync_n),
    .half_i   (half_clk),
    .quarter_i(quar_clk),
    .sel_i    (sel_i),
    .test_i   (test_i),
    .oe_ni    (oe_ni),
    .y_o      (y_o),
    .y_oe_o   (y_oe_o)
  );

  // R7: both derived clocks hold low while the synchronized reset is active
  p_reset_low_r7: assert property (@(posedge src_clk_i)
    !rst_sync_n |-> (!half_clk && !quar_clk));

endmodule

// File: tb/clk_bank_divider_tb_top.sv
`timescale 1ns/1ps
module clk_bank_divider_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr;
  logic [1:0]  sel;
  logic        test;
  logic        oe_n;
  logic [11:0] y;
  logic [11:0] y_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clk_bank_divider dut_i (
    .src_clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .sel_i(sel),
    .test_i(test), .oe_ni(oe_n), .y_o(y), .y_oe_o(y_oe)
  );

  // Reference clocks built from the requirements (R1, R2, R6, R7).
  logic ref_h, ref_q, ref_clr_prev;
  int   ref_rel;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_h <= 0; ref_q <= 0; ref_clr_prev <= 0; ref_rel <= 0;
    end else if (ref_rel < 2) begin
      ref_rel <= ref_rel + 1;
    end else begin
      ref_clr_prev <= clr;
      ref_h <= ~ref_h;
      if (ref_clr_prev && !clr) ref_q <= 1'b0;
      else if (!ref_h)          ref_q <= ~ref_q;
    end
  end

  function automatic logic [11:0] exp_y();
    logic [11:0] r;
    for (int b = 0; b < 4; b++) begin
      logic v;
      v = (b < 3 && int'(sel) > b) ? ref_q : ref_h;
      if (test) v = clk;
      if (oe_n) v = 1'b0;
      for (int o = 0; o < 3; o++) r[b*3+o] = v;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_ports(input string req);
    check({req, " y"}, y, exp_y());
    check({req, " oe"}, y_oe, oe_n ? 12'h000 : 12'hfff);
  endtask

  task automatic run_cycles(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #0.5;
      check_ports(req);
    end
  endtask

  // R7: reset state and release timing
  task automatic t_reset();
    @(negedge clk); rst_n = 0; sel = 2'd3; #0.5;
    check("R7 in reset", y, 12'h000);
    check("R8 enabled in reset", y_oe, 12'hfff);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #0.5; check("R7 edge1", y, 12'h000);
    @(negedge clk); #0.5; check("R7 edge2", y, 12'h000);
    @(negedge clk); #0.5; check("R7 edge3 common rise", y, 12'hfff);
    @(negedge clk); #0.5; check("R1 half falls, R2 quarter holds", y, 12'h1ff);
  endtask

  // R3 R4 R5 R10: every select value
  task automatic t_select();
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); sel = 2'(s); #0.5;
      check_ports("R10 select immediate");
      run_cycles("R3 R4 R5 select pattern", 8);
    end
  endtask

  // R6: clear at both half-clock phases
  task automatic t_clear();
    sel = 2'd3;
    for (int ph = 0; ph < 2; ph++) begin
      do @(negedge clk); while (ref_h !== 1'(ph) || ref_q !== 1'b1);
      clr = 0;
      @(negedge clk); #0.5;
      check("R6 quarter forced low", y[2:0], 3'b000);
      check("R6 half undisturbed", {2'b00, y[9]}, {2'b00, ph == 0});
      run_cycles("R6 after clear", 6);
      @(negedge clk); clr = 1;
      run_cycles("R6 clear raised", 3);
    end
  endtask

  // R8: disable, also with test high
  task automatic t_disable();
    @(negedge clk); oe_n = 1; #0.5;
    check("R8 disabled data", y, 12'h000);
    check("R8 disabled enable", y_oe, 12'h000);
    test = 1;
    @(posedge clk); #1;
    check("R8 disabled over test", y, 12'h000);
    @(negedge clk); test = 0; oe_n = 0; #0.5;
    check_ports("R8 re-enabled");
  endtask

  // R9: bypass follows the source clock in both phases
  task automatic t_test();
    for (int s = 0; s < 4; s += 3) begin
      @(negedge clk); sel = 2'(s); test = 1; #0.5;
      check("R9 low phase", y, 12'h000);
      @(posedge clk); #1;
      check("R9 high phase", y, 12'hfff);
    end
    @(negedge clk); test = 0; #0.5;
    check_ports("R9 bypass off");
  endtask

  initial begin
    rst_n = 0; clr = 1; sel = 0; test = 0; oe_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_select();
    t_clear();
    t_disable();
    t_test();
    run_cycles("R1 R2 final run", 8);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule